// File: doc/BRIEF.md
# OTP fuse controller command engine

This block sits between a 32-bit register bus and a one-time-programmable fuse macro. Software powers the macro, loads a data word and writes a single control register. That one write starts a command, which can be a shadow read, a program or a permanent-lock program. The block then runs a fixed-length busy window. During that window it reads lock state, drives at most one write strobe into the macro, reads the result back and reports the outcome. The outcome appears as status bits and as per-word error and disturbed bitmaps.

A shadow read copies a fuse word into a bank of shadow registers, and software reads the word from there. Software may also overwrite any shadow word directly. Programming can only set fuse bits. If a program is aimed at a permanently locked word, or is issued while the sticky global program lock is set, the array is left untouched and the program-failure flag is raised. A permanent lock uses its own address and data encoding into a separate lock area of the macro.

The fuse port is a plain memory-style port with no back-pressure. It has a combinational read, a one-cycle write strobe and a power request/acknowledge pair. The command timing is fixed by a parameter, so no valid/ready handshake is needed there. The register bus is a single-cycle slave: a write is taken on any clock edge where select and write-enable are both high, and read data follows the address combinationally.

Top module: `otp_ctrl`

## Requirements
- R1: After reset, the configuration, status, write-data, shadow words and all error and disturbed bitmaps read as zero.
- R2: Configuration bit 0 drives the power request. Status bit 5 shows the registered power acknowledge. A control write (offset 0x004) made while status bit 5 is clear starts nothing.
- R3: An accepted control write sets status bit 3 (busy) for exactly BUSY_CYCLES cycles, starting with the cycle after the write. While busy, status bits [2:0] show 1 for a shadow read, 2 for a program and 3 for a permanent lock. They show 0 when idle.
- R4: A control write made while busy, or one whose index field (bits [7:0]) is WORDS or more, is ignored.
- R5: A control write with bit 8 clear is a shadow read. It copies fuse word N (index in bits [7:0]) to the shadow word at offset 0x200 + 4*N.
- R6: A bus write to offset 0x200 + 4*N replaces shadow word N.
- R7: A control write with bit 8 set and bit 9 clear is a program. It ORs the write-data register (offset 0x008, sampled when the command starts) into fuse word N. Status bit 4 (program failure) is cleared at the start of each command.
- R8: After a program, status bit 4 is set when the stored word differs from the requested value.
- R9: A control write with bits 8 and 9 both set is a permanent lock of word N. Below UPPER_BASE the lock area address is N>>3 and the data is 3<<(2*(N&7)). Otherwise the address is (N>>4)+2 and the data is 1<<(N&15).
- R10: Configuration bit 1 is a global program lock that stays set until reset. A program made while that lock is set, or aimed at a word whose permanent-lock bits are non-zero, leaves the array unchanged and sets status bit 4. Other words that share the same lock area word are unaffected.
- R11: Word N's error flag is bit N mod 32 of the register at 0x034 + 4*(N div 32). Its disturbed flag is the same bit at 0x01C + 4*(N div 32). A shadow read or a program rewrites both flags from the macro's read-back. A permanent lock rewrites only the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Bus write enable |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational on bus_addr |
| fz_pwr_req | output | 1 | Fuse macro power request |
| fz_pwr_ack | input | 1 | Fuse macro power is up |
| fz_rd_lock | output | 1 | Read targets the lock area |
| fz_rd_addr | output | IW | Read word address |
| fz_rd_data | input | 32 | Read data |
| fz_rd_err | input | 1 | Read-back error for the addressed word |
| fz_rd_dist | input | 1 | Read-back disturbed indication |
| fz_wr_en | output | 1 | One-cycle write strobe |
| fz_wr_lock | output | 1 | Write targets the lock area |
| fz_wr_addr | output | IW | Write word address |
| fz_wr_data | output | 32 | Bits to set |

## Verification
Shadow reads are tried on a lower word and on an upper word with different data. A shadow word is overwritten by the bus and then refreshed by a read, which shows the copy path is distinct from the bus path. Programs are tried on a blank word and on a word with a bit already set that the request leaves clear, which tells a clean program apart from a mismatch failure. Permanent locks are applied on both sides of UPPER_BASE to separate the two encodings. A follow-up program on the locked word, and another on its neighbour in the same lock word, show that only the locked word's bits block. Injected error and disturbed read-backs on words in different banks check the bitmap placement. Writes made while unpowered, while busy or out of range are each shown to leave the shadow and status unchanged.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE = 3'd0,
    MODE_READ = 3'd1,
    MODE_PROG = 3'd2,
    MODE_LOCK = 3'd3
  } otp_mode_e;

  localparam logic [11:0] OFS_CONF   = 12'h000;
  localparam logic [11:0] OFS_CTRL   = 12'h004;
  localparam logic [11:0] OFS_WDATA  = 12'h008;
  localparam logic [11:0] OFS_STAT   = 12'h00C;
  localparam logic [11:0] OFS_DIST   = 12'h01C;
  localparam logic [11:0] OFS_ERR    = 12'h034;
  localparam logic [11:0] OFS_SHADOW = 12'h200;

  localparam int CTRL_PROG_BIT = 8;
  localparam int CTRL_LOCK_BIT = 9;
endpackage

// File: rtl/otp_lock_map.sv
module otp_lock_map #(
  parameter int unsigned IW         = 7,
  parameter int unsigned UPPER_BASE = 32
) (
  input  logic [IW-1:0] idx,
  output logic [IW-1:0] lk_addr,
  output logic [31:0]   lk_data,
  output logic          lk_upper
);
  always_comb begin
    lk_upper = ({{(32-IW){1'b0}}, idx} >= UPPER_BASE);
    if (!lk_upper) begin
      lk_addr = idx >> 3;
      lk_data = 32'd3 << {idx[2:0], 1'b0};
    end else begin
      lk_addr = (idx >> 4) + IW'(2);
      lk_data = 32'd1 << idx[3:0];
    end
  end
endmodule

// File: rtl/otp_seq.sv
module otp_seq #(
  parameter int unsigned BUSY_CYCLES = 8,
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic stage0,
  output logic stage1,
  output logic stage2
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CW'(BUSY_CYCLES - 1)) busy <= 1'b0;
      cnt <= cnt + CW'(1);
    end
  end

  assign stage0 = busy && (cnt == CW'(0));
  assign stage1 = busy && (cnt == CW'(1));
  assign stage2 = busy && (cnt == CW'(2));
endmodule

// File: rtl/otp_flag_bank.sv
module otp_flag_bank #(
  parameter int unsigned IW   = 7,
  parameter int unsigned NREG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [IW-1:0] idx,
  input  logic          val,
  output logic [31:0]   flags [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= '0;
      else if (upd && ((32'(idx) >> 5) == g)) flags[g][idx[4:0]] <= val;
    end
  end
endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned WORDS       = 96,
  parameter int unsigned UPPER_BASE  = 32,
  parameter int unsigned BUSY_CYCLES = 8,
  localparam int unsigned IW   = $clog2(WORDS),
  localparam int unsigned NREG = (WORDS + 31) / 32,
  localparam int unsigned BW   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [11:0]   bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          fz_pwr_req,
  input  logic          fz_pwr_ack,
  output logic          fz_rd_lock,
  output logic [IW-1:0] fz_rd_addr,
  input  logic [31:0]   fz_rd_data,
  input  logic          fz_rd_err,
  input  logic          fz_rd_dist,
  output logic          fz_wr_en,
  output logic          fz_wr_lock,
  output logic [IW-1:0] fz_wr_addr,
  output logic [31:0]   fz_wr_data
);
  logic            conf_pwr, conf_glock, pwr_up, fail, blocked;
  logic [31:0]     wdata_r, cur_data;
  logic [IW-1:0]   cur_idx, lk_addr;
  logic [31:0]     lk_data;
  logic            lk_upper;
  otp_mode_e       cur_mode;
  logic            busy, stage0, stage1, stage2;
  logic [31:0]     shadow [WORDS];
  logic [31:0]     err_w  [NREG];
  logic [31:0]     dist_w [NREG];

  wire bus_wr   = bus_sel && bus_we;
  wire ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
  wire idx_ok   = ({24'd0, bus_wdata[7:0]} < WORDS);
  wire start    = ctrl_wr && pwr_up && !busy && idx_ok;
  wire is_read  = (cur_mode == MODE_READ);
  wire is_prog  = (cur_mode == MODE_PROG);
  wire is_lock  = (cur_mode == MODE_LOCK);

  wire [11:0] sh_ofs  = bus_addr - OFS_SHADOW;
  wire [11:0] er_ofs  = bus_addr - OFS_ERR;
  wire [11:0] di_ofs  = bus_addr - OFS_DIST;
  wire        sh_hit  = (bus_addr >= OFS_SHADOW) && ({20'd0, sh_ofs} < 4 * WORDS);
  wire        er_hit  = (bus_addr >= OFS_ERR) && ({20'd0, er_ofs} < 4 * NREG);
  wire        di_hit  = (bus_addr >= OFS_DIST) && ({20'd0, di_ofs} < 4 * NREG);
  wire [IW-1:0] sh_idx = sh_ofs[IW+1:2];
  wire [BW-1:0] er_idx = er_ofs[BW+1:2];
  wire [BW-1:0] di_idx = di_ofs[BW+1:2];

  otp_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .stage0(stage0), .stage1(stage1), .stage2(stage2)
  );

  otp_lock_map #(.IW(IW), .UPPER_BASE(UPPER_BASE)) u_map (
    .idx(cur_idx), .lk_addr(lk_addr), .lk_data(lk_data), .lk_upper(lk_upper)
  );

  otp_flag_bank #(.IW(IW), .NREG(NREG)) u_err (
    .clk(clk), .rst_n(rst_n),
    .upd((stage0 && is_read) || (stage2 && !is_read)),
    .idx(cur_idx), .val(fz_rd_err), .flags(err_w)
  );

  otp_flag_bank #(.IW(IW), .NREG(NREG)) u_dist (
    .clk(clk), .rst_n(rst_n),
    .upd((stage0 && is_read) || (stage2 && is_prog)),
    .idx(cur_idx), .val(fz_rd_dist), .flags(dist_w)
  );

  // Registers and command capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf_pwr   <= 1'b0;
      conf_glock <= 1'b0;
      pwr_up     <= 1'b0;
      wdata_r    <= '0;
      cur_data   <= '0;
      cur_idx    <= '0;
      cur_mode   <= MODE_IDLE;
      fail       <= 1'b0;
      blocked    <= 1'b0;
    end else begin
      pwr_up <= fz_pwr_ack;
      if (bus_wr && bus_addr == OFS_CONF) begin
        conf_pwr   <= bus_wdata[0];
        conf_glock <= conf_glock | bus_wdata[1];
      end
      if (bus_wr && bus_addr == OFS_WDATA) wdata_r <= bus_wdata;
      if (start) begin
        cur_idx  <= bus_wdata[IW-1:0];
        cur_data <= wdata_r;
        fail     <= 1'b0;
        if (!bus_wdata[CTRL_PROG_BIT])     cur_mode <= MODE_READ;
        else if (bus_wdata[CTRL_LOCK_BIT]) cur_mode <= MODE_LOCK;
        else                               cur_mode <= MODE_PROG;
      end
      if (stage0) blocked <= conf_glock || (is_prog && ((fz_rd_data & lk_data) != '0));
      if (stage2 && is_prog) fail <= blocked || (fz_rd_data != cur_data);
      if (stage2 && is_lock) fail <= blocked || ((fz_rd_data & lk_data) != lk_data);
    end
  end

  // Shadow bank: command capture wins over a bus write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) shadow[i] <= '0;
    end else if (stage0 && is_read) begin
      shadow[cur_idx] <= fz_rd_data;
    end else if (bus_wr && sh_hit) begin
      shadow[sh_idx] <= bus_wdata;
    end
  end

  // Fuse port
  assign fz_pwr_req = conf_pwr;
  assign fz_rd_lock = (stage0 && is_prog) || (stage2 && is_lock);
  assign fz_rd_addr = fz_rd_lock ? lk_addr : cur_idx;
  assign fz_wr_en   = stage1 && !is_read && !blocked;
  assign fz_wr_lock = is_lock;
  assign fz_wr_addr = is_lock ? lk_addr : cur_idx;
  assign fz_wr_data = is_lock ? lk_data : cur_data;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_CONF)       bus_rdata = {30'd0, conf_glock, conf_pwr};
    else if (bus_addr == OFS_WDATA) bus_rdata = wdata_r;
    else if (bus_addr == OFS_STAT)
      bus_rdata = {26'd0, pwr_up, fail, busy, (busy ? cur_mode : MODE_IDLE)};
    else if (di_hit) bus_rdata = dist_w[di_idx];
    else if (er_hit) bus_rdata = err_w[er_idx];
    else if (sh_hit) bus_rdata = shadow[sh_idx];
  end

  wire unused_ok = &{1'b0, lk_upper, sh_ofs[11:IW+2], sh_ofs[1:0],
                     er_ofs[11:BW+2], er_ofs[1:0], di_ofs[11:BW+2], di_ofs[1:0],
                     bus_wdata[31:CTRL_LOCK_BIT+1]};
endmodule

// File: rtl/otp_ctrl_chk.sv
module otp_ctrl_chk #(
  parameter int unsigned WORDS       = 96,
  parameter int unsigned UPPER_BASE  = 32,
  parameter int unsigned BUSY_CYCLES = 8,
  localparam int unsigned IW = $clog2(WORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          pwr_up,
  input logic          conf_glock,
  input logic          fz_wr_en,
  input logic          fz_wr_lock,
  input logic [31:0]   fz_wr_data,
  input logic [IW-1:0] cur_idx
);
  logic [15:0] blen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen <= '0;
    else if (busy) blen <= blen + 16'd1;
    else           blen <= '0;
  end

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == 16'(BUSY_CYCLES)));

  // R2
  start_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_up));

  // R4
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_idx));

  // R10
  glock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fz_wr_en |-> !conf_glock);

  // R7
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fz_wr_en |=> !fz_wr_en);

  // R9
  lock_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fz_wr_en && fz_wr_lock && ({{(32-IW){1'b0}}, cur_idx} < UPPER_BASE))
      |-> ($countones(fz_wr_data) == 2));

  // R9
  lock_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fz_wr_en && fz_wr_lock && ({{(32-IW){1'b0}}, cur_idx} >= UPPER_BASE))
      |-> ($countones(fz_wr_data) == 1));
endmodule

bind otp_ctrl otp_ctrl_chk #(
  .WORDS(WORDS), .UPPER_BASE(UPPER_BASE), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pwr_up(pwr_up),
  .conf_glock(conf_glock), .fz_wr_en(fz_wr_en), .fz_wr_lock(fz_wr_lock),
  .fz_wr_data(fz_wr_data), .cur_idx(cur_idx)
);

// File: tb/tb_otp_ctrl.sv
module tb_otp_ctrl;
  localparam int unsigned WORDS = 96, UPPER = 32, BUSY = 8, IW = 7;
  localparam logic [11:0] A_CONF = 12'h000, A_CTRL = 12'h004, A_WD = 12'h008,
                          A_ST = 12'h00C, A_DI = 12'h01C, A_ER = 12'h034, A_SH = 12'h200;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic fz_pwr_req, fz_pwr_ack, fz_rd_lock, fz_rd_err, fz_rd_dist;
  logic fz_wr_en, fz_wr_lock;
  logic [IW-1:0] fz_rd_addr, fz_wr_addr;
  logic [31:0] fz_rd_data, fz_wr_data;

  always #10 clk = ~clk;

  otp_ctrl #(.WORDS(WORDS), .UPPER_BASE(UPPER), .BUSY_CYCLES(BUSY)) dut (.*);

  // Behavioural fuse macro
  logic [31:0] fuse [WORDS];
  logic [31:0] lockw [16];
  logic        err_inj [WORDS];
  logic        dist_inj [WORDS];
  logic [IW-1:0] last_la;
  logic [31:0]   last_ld;
  logic [2:0]    pwr_sh = 0;

  assign fz_pwr_ack = pwr_sh[2];
  assign fz_rd_data = fz_rd_lock ? lockw[fz_rd_addr[3:0]] : fuse[fz_rd_addr];
  assign fz_rd_err  = fz_rd_lock ? 1'b0 : err_inj[fz_rd_addr];
  assign fz_rd_dist = fz_rd_lock ? 1'b0 : dist_inj[fz_rd_addr];

  always @(posedge clk) begin
    pwr_sh <= {pwr_sh[1:0], fz_pwr_req};
    if (fz_wr_en) begin
      if (fz_wr_lock) begin
        lockw[fz_wr_addr[3:0]] = lockw[fz_wr_addr[3:0]] | fz_wr_data;
        last_la = fz_wr_addr;
        last_ld = fz_wr_data;
      end else begin
        fuse[fz_wr_addr] = fuse[fz_wr_addr] | fz_wr_data;
      end
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      rd(A_ST, s);
      if (!s[3]) return;
      @(negedge clk);
    end
  endtask

  task automatic cmd(input logic [31:0] c);
    wr(A_CTRL, c);
    wait_idle();
  endtask

  task automatic shadow_read(input int n, output logic [31:0] v);
    cmd(32'(n));
    rd(12'(A_SH + 4 * n), v);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_ST, v);   check("R1 status", v, 0);
    rd(A_CONF, v); check("R1 conf", v, 0);
    rd(A_WD, v);   check("R1 wdata", v, 0);
    rd(12'(A_SH + 20), v); check("R1 shadow5", v, 0);
    rd(A_ER + 4, v); check("R1 err bank1", v, 0);
  endtask

  task automatic t_power();
    logic [31:0] v;
    fuse[3] = 32'hA5A5_0F0F;
    wr(A_CTRL, 32'd3);
    rd(A_ST, v); check("R2 unpowered busy", v[3], 0);
    repeat (10) @(negedge clk);
    rd(A_SH + 12, v); check("R2 unpowered shadow", v, 0);
    wr(A_CONF, 32'd1);
    repeat (6) @(negedge clk);
    rd(A_ST, v); check("R2 power status", v[5], 1);
  endtask

  task automatic t_read();
    logic [31:0] v;
    int n = 0;
    wr(A_CTRL, 32'd3);
    rd(A_ST, v); check("R3 mode read", v[2:0], 1);
    for (int i = 0; i < 50; i++) begin
      rd(A_ST, v);
      if (!v[3]) break;
      n++;
      @(negedge clk);
    end
    check("R3 busy length", 32'(n), BUSY);
    rd(A_ST, v); check("R3 idle mode", v[2:0], 0);
    rd(A_SH + 12, v); check("R5 shadow3", v, 32'hA5A5_0F0F);
    fuse[70] = 32'h1234_5678; dist_inj[70] = 1;
    shadow_read(70, v); check("R5 shadow70", v, 32'h1234_5678);
    rd(A_DI + 8, v); check("R11 dist bank2", v, 32'h40);
    rd(A_ER + 8, v); check("R11 err bank2", v, 0);
    dist_inj[70] = 0;
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    fuse[4] = 32'h11; fuse[5] = 32'h22;
    wr(A_CTRL, 32'd4);
    wr(A_CTRL, 32'd5);
    wait_idle();
    rd(A_SH + 20, v); check("R4 busy write ignored", v, 0);
    rd(A_SH + 16, v); check("R4 first read done", v, 32'h11);
    wr(A_CTRL, 32'd96);
    rd(A_ST, v); check("R4 out of range", v[3], 0);
  endtask

  task automatic t_shadow_wr();
    logic [31:0] v;
    fuse[7] = 32'h0000_0777;
    wr(A_SH + 28, 32'hDEAD_BEEF);
    rd(A_SH + 28, v); check("R6 direct write", v, 32'hDEAD_BEEF);
    shadow_read(7, v); check("R5 refresh after direct", v, 32'h0000_0777);
  endtask

  task automatic t_program();
    logic [31:0] v;
    wr(A_WD, 32'h0000_F00D);
    wr(A_CTRL, 32'h10A);
    rd(A_ST, v); check("R3 mode prog", v[2:0], 2);
    wait_idle();
    rd(A_ST, v); check("R7 no fail", v[4], 0);
    shadow_read(10, v); check("R7 programmed", v, 32'h0000_F00D);
    wr(A_WD, 32'h0000_0001);
    cmd(32'h10A);
    rd(A_ST, v); check("R8 mismatch fail", v[4], 1);
    shadow_read(10, v); check("R8 word value", v, 32'h0000_F00D);
    rd(A_ST, v); check("R7 fail cleared by next cmd", v[4], 0);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(A_CTRL, 32'h30A);
    rd(A_ST, v); check("R3 mode lock", v[2:0], 3);
    wait_idle();
    check("R9 lower addr", 32'(last_la), 1);
    check("R9 lower data", last_ld, 32'h30);
    rd(A_ST, v); check("R9 lock ok", v[4], 0);
    wr(A_WD, 32'h0000_F00F);
    cmd(32'h10A);
    rd(A_ST, v); check("R10 locked fail", v[4], 1);
    shadow_read(10, v); check("R10 locked unchanged", v, 32'h0000_F00D);
    wr(A_WD, 32'h7);
    cmd(32'h10B);
    rd(A_ST, v); check("R10 neighbour free", v[4], 0);
    cmd(32'h300 | 75);
    check("R9 upper addr", 32'(last_la), 6);
    check("R9 upper data", last_ld, 32'h800);
    cmd(32'h100 | 75);
    rd(A_ST, v); check("R10 upper locked fail", v[4], 1);
  endtask

  task automatic t_error();
    logic [31:0] v;
    err_inj[40] = 1;
    wr(A_WD, 32'h3);
    cmd(32'h100 | 40);
    rd(A_ER + 4, v); check("R11 err bank1 set", v, 32'h100);
    rd(A_ST, v); check("R7 prog 40 ok", v[4], 0);
    err_inj[40] = 0;
    shadow_read(40, v); check("R5 shadow40", v, 32'h3);
    rd(A_ER + 4, v); check("R11 err cleared", v, 0);
  endtask

  task automatic t_glock();
    logic [31:0] v;
    wr(A_CONF, 32'd3);
    rd(A_CONF, v); check("R10 glock set", v, 3);
    wr(A_CONF, 32'd1);
    rd(A_CONF, v); check("R10 glock sticky", v, 3);
    wr(A_WD, 32'h5);
    cmd(32'h100 | 20);
    rd(A_ST, v); check("R10 glock fail", v[4], 1);
    shadow_read(20, v); check("R10 glock unchanged", v, 0);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      fuse[i] = 0; err_inj[i] = 0; dist_inj[i] = 0;
    end
    for (int i = 0; i < 16; i++) lockw[i] = 0;
    last_la = 0; last_ld = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_power();
    t_read();
    t_ignore();
    t_shadow_wr();
    t_program();
    t_lock();
    t_error();
    t_glock();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule